// File: doc/BRIEF.md
# Maximal-Length Pseudo-Random Sequence Generator

This block is a shift register of `STAGES` flip-flops (3 to 7) whose first stage takes the XOR of two later stages. With the right tap pair the register steps through every non-zero pattern exactly once before it repeats, so the sequence has 2^STAGES − 1 states. The tap pair comes from a table built into the block and indexed by the stage count. The user does not set it.

Stages are numbered 1 to STAGES. Stage 1 is the most significant bit of `state_o`, and stage STAGES is bit 0. On each enabled clock the contents move one place from stage 1 toward stage STAGES. The tap table is:

| Stages | Taps |
|---|---|
| 3 | 2, 3 |
| 4 | 3, 4 |
| 5 | 3, 5 |
| 6 | 5, 6 |
| 7 | 6, 7 |

A load strobe writes a seed in one cycle. A seed of zero would lock the register in the all-zero state, so the block replaces a zero seed with 00..01. The last stage is also driven out as a serial bit.

Top module: `lfsr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state is 00..01 (only bit 0 set) until the first load or step.
- R2: On a step, bit i of the new state equals bit i+1 of the old state for every i from 0 to STAGES−2, so data moves from stage 1 toward the last stage.
- R3: On a step, the new stage 1 (bit STAGES−1) is the XOR of the two tap stages in the table. Stage k is bit STAGES−k.
- R4: With STAGES = 4 and starting from 0001, the states in hex are 1, 8, 4, 2, 9, C, 6, B, 5, A, D, E, F, 7, 3, and then 1 again.
- R5: Starting from 00..01, the state returns to 00..01 after exactly 2^STAGES − 1 steps, and no state appears twice within that period.
- R6: The state is never all zeros.
- R7: When `step_en` and `load_en` are both low, the state holds its value.
- R8: When `load_en` is high and `seed_i` is non-zero, the next state equals `seed_i`. A load takes priority over `step_en`.
- R9: When `load_en` is high and `seed_i` is zero, the next state is 00..01.
- R10: `serial_o` always shows the last stage (bit 0 of the state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the sequence one step |
| load_en | input | 1 | Write the seed this cycle (takes priority over stepping) |
| seed_i | input | STAGES | Seed value; zero is replaced by 00..01 |
| state_o | output | STAGES | Parallel state; stage 1 is the MSB |
| serial_o | output | 1 | Last stage, the serial output |

## Verification
One instance of each stage count from 3 to 7 runs from the reset seed through 127 steps in parallel. Each state is compared with a reference step computed in the bench, which separates wrong taps and wrong shift direction from correct behaviour. A visited-state bitmap per size shows whether the period is exactly 2^STAGES − 1 with no early repeat. For four stages, the fixed 15-entry order is also checked literally.

After the sweep, a held enable checks that the state freezes. A non-zero seed is loaded both with and without the step enable, which confirms that a load wins over a step. A zero seed is then loaded to check the guard. An all-ones seed, followed by a step, checks the feedback from a pattern that the reset seed reaches only late in the sequence.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  localparam int unsigned MIN_STAGES = 3;
  localparam int unsigned MAX_STAGES = 7;

  // Operation chosen for the register in a given cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } lfsr_op_e;

  // Far tap: always the last stage
  function automatic int unsigned far_tap(input int unsigned n);
    return n;
  endfunction

  // Near tap: the second feedback stage for a maximal-length sequence
  function automatic int unsigned near_tap(input int unsigned n);
    case (n)
      3:       return 2;
      4:       return 3;
      5:       return 3;
      6:       return 5;
      7:       return 6;
      default: return n - 1;
    endcase
  endfunction

endpackage

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
  import lfsr_pkg::*;
(
  input  logic     load_en,
  input  logic     step_en,
  output lfsr_op_e op_o
);

  // A load takes priority over a step
  always_comb begin
    if (load_en)      op_o = OP_LOAD;
    else if (step_en) op_o = OP_SHIFT;
    else              op_o = OP_HOLD;
  end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned STAGES = 4
) (
  input  logic [STAGES-1:0] seed_i,
  output logic [STAGES-1:0] seed_safe_o
);

  localparam logic [STAGES-1:0] SAFE_SEED = STAGES'(1);

  // A zero seed would lock the register, so substitute 00..01
  always_comb begin
    if (|seed_i) seed_safe_o = seed_i;
    else         seed_safe_o = SAFE_SEED;
  end

endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned STAGES   = 4,
  parameter int unsigned TAP_FAR  = 4,
  parameter int unsigned TAP_NEAR = 3
) (
  input  logic [STAGES-1:0] state_i,
  output logic              fb_o
);

  // Stage k is bit STAGES-k
  localparam int unsigned IDX_FAR  = STAGES - TAP_FAR;
  localparam int unsigned IDX_NEAR = STAGES - TAP_NEAR;

  logic [STAGES-1:0] tap_mask;

  // Build the tap mask one bit per stage
  for (genvar b = 0; b < int'(STAGES); b++) begin : g_mask
    if (b == int'(IDX_FAR) || b == int'(IDX_NEAR)) begin : g_on
      assign tap_mask[b] = 1'b1;
    end else begin : g_off
      assign tap_mask[b] = 1'b0;
    end
  end

  assign fb_o = ^(state_i & tap_mask);

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
  import lfsr_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lfsr_op_e          op_i,
  input  logic              fb_i,
  input  logic [STAGES-1:0] seed_i,
  output logic [STAGES-1:0] state_o
);

  localparam logic [STAGES-1:0] RESET_SEED = STAGES'(1);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;

  // Next-state logic
  always_comb begin
    case (op_i)
      OP_SHIFT: state_d = {fb_i, state_q[STAGES-1:1]};
      OP_LOAD:  state_d = seed_i;
      default:  state_d = state_q;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_SEED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_HOLD) |=> $stable(state_q));

  a_r2_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SHIFT) |=> state_q[STAGES-2:0] == $past(state_q[STAGES-1:1]));

  a_r3_first_stage_fb: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SHIFT) |=> state_q[STAGES-1] == $past(fb_i));

  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD) |=> state_q == $past(seed_i));

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
  import lfsr_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              load_en,
  input  logic [STAGES-1:0] seed_i,
  output logic [STAGES-1:0] state_o,
  output logic              serial_o
);

  localparam int unsigned     TAP_FAR  = far_tap(STAGES);
  localparam int unsigned     TAP_NEAR = near_tap(STAGES);
  localparam logic [STAGES-1:0] ONE_STATE = STAGES'(1);

  lfsr_op_e          op;
  logic              fb;
  logic [STAGES-1:0] seed_safe;

  lfsr_op_decode u_decode (
    .load_en (load_en),
    .step_en (step_en),
    .op_o    (op)
  );

  lfsr_seed_guard #(.STAGES(STAGES)) u_guard (
    .seed_i      (seed_i),
    .seed_safe_o (seed_safe)
  );

  lfsr_feedback #(
    .STAGES   (STAGES),
    .TAP_FAR  (TAP_FAR),
    .TAP_NEAR (TAP_NEAR)
  ) u_fb (
    .state_i (state_o),
    .fb_o    (fb)
  );

  lfsr_state_reg #(.STAGES(STAGES)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op),
    .fb_i    (fb),
    .seed_i  (seed_safe),
    .state_o (state_o)
  );

  assign serial_o = state_o[0];

  a_r1_reset_seed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> state_o == ONE_STATE);

  a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != '0);

  a_r9_zero_seed_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && seed_i == '0) |=> state_o == ONE_STATE);

  a_r3_tap_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=>
      state_o[STAGES-1] == ($past(state_o[STAGES-TAP_FAR]) ^ $past(state_o[STAGES-TAP_NEAR])));

  a_r10_serial_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> serial_o == $past(state_o[1]));

endmodule

// File: tb/lfsr_gen_tb.sv
`timescale 1ns/1ps
module lfsr_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_en;
  logic       load_en;
  logic [7:0] seed;

  logic [7:0] st_all [3:7];
  logic       ser_all [3:7];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  for (genvar g = 3; g <= 7; g++) begin : g_dut
    logic [g-1:0] st;
    logic         ser;
    if (g == 4) begin : g_named
      lfsr_gen #(.STAGES(g)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
        .seed_i(seed[g-1:0]), .state_o(st), .serial_o(ser));
    end else begin : g_other
      lfsr_gen #(.STAGES(g)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
        .seed_i(seed[g-1:0]), .state_o(st), .serial_o(ser));
    end
    assign st_all[g]  = 8'(st);
    assign ser_all[g] = ser;
  end

  function automatic logic [7:0] mask_of(input int n);
    return 8'((1 << n) - 1);
  endfunction

  function automatic int period_of(input int n);
    return (1 << n) - 1;
  endfunction

  // Reference step: stage k is bit n-k, taps from the requirement table
  function automatic logic [7:0] ref_next(input int n, input logic [7:0] s);
    int a;
    int b;
    logic fbit;
    a = n;
    case (n)
      3: b = 2;
      4: b = 3;
      5: b = 3;
      6: b = 5;
      default: b = 6;
    endcase
    fbit = s[n-a] ^ s[n-b];
    return ((s >> 1) | (8'(fbit) << (n - 1))) & mask_of(n);
  endfunction

  function automatic logic [3:0] order4(input int k);
    case (k % 15)
      0: return 4'h1;  1: return 4'h8;  2: return 4'h4;  3: return 4'h2;
      4: return 4'h9;  5: return 4'hC;  6: return 4'h6;  7: return 4'hB;
      8: return 4'h5;  9: return 4'hA; 10: return 4'hD; 11: return 4'hE;
      12: return 4'hF; 13: return 4'h7; default: return 4'h3;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  logic [7:0]   exp_st [3:7];
  logic [127:0] seen   [3:7];

  initial begin
    rst_n = 1'b0; step_en = 1'b0; load_en = 1'b0; seed = '0;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    for (int n = 3; n <= 7; n++) check($sformatf("R1 reset N=%0d", n), st_all[n], 8'h01);
    rst_n = 1'b1;
    tick();
    for (int n = 3; n <= 7; n++) begin
      check($sformatf("R1 after release N=%0d", n), st_all[n], 8'h01);
      exp_st[n] = 8'h01;
      seen[n]   = '0;
      seen[n][1] = 1'b1;
    end

    // Full sweep: R2, R3, R4, R5, R6, R10
    step_en = 1'b1;
    for (int c = 1; c <= 127; c++) begin
      tick();
      for (int n = 3; n <= 7; n++) begin
        exp_st[n] = ref_next(n, exp_st[n]);
        check($sformatf("R2/R3 step %0d N=%0d", c, n), st_all[n], exp_st[n]);
        check($sformatf("R10 serial N=%0d", n), 8'(ser_all[n]), 8'(st_all[n][0]));
        if (st_all[n] == 8'h00) check($sformatf("R6 zero N=%0d", n), st_all[n], 8'h01);
        if (c < period_of(n)) begin
          if (seen[n][st_all[n][6:0]] || st_all[n] == 8'h01)
            check($sformatf("R5 early repeat step %0d N=%0d", c, n), st_all[n], 8'hFF);
          seen[n][st_all[n][6:0]] = 1'b1;
        end
        if (c == period_of(n))
          check($sformatf("R5 period N=%0d", n), st_all[n], 8'h01);
      end
      if (c <= 15) check($sformatf("R4 order step %0d", c), st_all[4], 8'(order4(c)));
    end

    // R7: hold
    step_en = 1'b0;
    for (int n = 3; n <= 7; n++) exp_st[n] = st_all[n];
    for (int c = 0; c < 4; c++) begin
      tick();
      for (int n = 3; n <= 7; n++) check($sformatf("R7 hold N=%0d", n), st_all[n], exp_st[n]);
    end

    // R8: load wins over step
    step_en = 1'b1; load_en = 1'b1; seed = 8'hA5;
    tick();
    for (int n = 3; n <= 7; n++) check($sformatf("R8 load N=%0d", n), st_all[n], 8'hA5 & mask_of(n));

    // R9: zero seed guarded
    step_en = 1'b0; seed = 8'h00;
    tick();
    for (int n = 3; n <= 7; n++) check($sformatf("R9 zero seed N=%0d", n), st_all[n], 8'h01);

    // R8: load without step, then step from all ones (R3)
    seed = 8'hFF;
    tick();
    for (int n = 3; n <= 7; n++) check($sformatf("R8 load idle N=%0d", n), st_all[n], mask_of(n));
    load_en = 1'b0; step_en = 1'b1;
    tick();
    for (int n = 3; n <= 7; n++)
      check($sformatf("R3 step from ones N=%0d", n), st_all[n], ref_next(n, mask_of(n)));
    step_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule